// File: doc/BRIEF.md
# Register-Launched Single-Transfer Bridge

This block sits between a host register port and a downstream request/acknowledge bus. Software stages one downstream access in a handful of registers: direction, size, target address and (for writes) data. It then arms completion by clearing a sticky status bit and launches the access with a separate trigger write. The bridge drives the request until the far side answers with an acknowledge, an error or a retry, or until a fixed cycle limit runs out.

When the access ends, a status word records how it ended and a sticky completion bit is raised. A mask decides whether that bit also drives the interrupt line. Software polls the completion bit and then reads the status word and, for a read, the captured data. Both stay valid until the next launch.

Retries are absorbed in hardware up to a programmable limit, so software only sees the final outcome. The host port is a single-cycle register port with a combinational read path.

Top module: `regtrig_bridge`

## Requirements
- R1: After reset, status (0x80), completion status (0x48), mask (0x44), read data (0x84) and the interrupt line are all zero. The retry limit (0x64) reads 0x10 and the downstream request is low.
- R2: The host can read back each stored field at its offset: direction bit 0 at 0x14 (1 = read, 0 = write), size bits 1:0 at 0x18, address at 0x1C, write data at 0x20, retry limit bits 7:0 at 0x64, and mask bit 16 at 0x44. The trigger offset 0x04 and any unmapped offset read zero.
- R3: A write to 0x04 with bit 0 set while idle raises the request on the next cycle. The request carries the staged address, data and size, with the write strobe equal to the inverse of the direction bit. Status then shows busy (bit 5) with flags 4:0 cleared.
- R4: A trigger written while a transfer is outstanding is ignored. Register writes made during a transfer do not alter the request that is in flight.
- R5: An acknowledge ends the transfer at the edge where it is sampled. Size 3 (fullword) sets status bit 1; size 0 (byte) and size 1 (halfword) set status bit 0; size 2 is handled as fullword. Busy clears at the same edge.
- R6: An acknowledged read stores the downstream data at 0x84, reduced to the low 8 bits for size 0, to the low 16 bits for size 1, and kept whole for sizes 2 and 3. Writes, errors, retries and timeouts leave 0x84 unchanged.
- R7: An error response ends the transfer with status bit 2 set.
- R8: A retry response while fewer retries than the limit have been used drops the request for exactly one cycle and reissues the same access. A retry response when the limit is already used ends the transfer with status bit 3 set, so at most limit + 1 attempts are made.
- R9: If an attempt sees no response for TMO_CYC consecutive request cycles, the transfer ends with status bit 4 set. The count restarts for each attempt.
- R10: When several responses arrive in the same cycle, error outranks retry, and retry outranks acknowledge.
- R11: Completion sets bit 16 of 0x48 whatever the mask holds. The bit stays set until the host writes 0x40 with bit 0 set. A completion in the same cycle as such a clear leaves the bit set.
- R12: The interrupt line is high exactly when completion bit 16 and mask bit 16 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Host access strobe |
| reg_we | input | 1 | Host write enable (with reg_sel) |
| reg_ofs | input | OFS_W | Host byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational on reg_ofs) |
| irq | output | 1 | Masked completion interrupt |
| dn_req | output | 1 | Downstream request |
| dn_we | output | 1 | Downstream write strobe (0 = read) |
| dn_size | output | 2 | Downstream transfer size |
| dn_addr | output | 32 | Downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream acknowledge pulse |
| dn_err | input | 1 | Downstream error pulse |
| dn_retry | input | 1 | Downstream retry pulse |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The assertions assume that downstream response pulses are only meaningful while the request is high. The bench responder therefore raises them only on request cycles, holding each for one cycle and dropping it at the next falling edge. The checks also assume one host access per cycle and a staged command that is stable from programming to trigger; the bench drives the host port through tasks that issue a single access and then idle. Simultaneous responses, retries beyond the limit and silent downstream targets are all produced on purpose, so the priority, retry-bound and timeout properties are exercised rather than only held vacuously.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  localparam int DATA_W = 32;
  localparam int ISTAT_BIT = 16;
  localparam int BUSY_BIT = 5;

  localparam logic [7:0] OFS_TRIG  = 8'h04;
  localparam logic [7:0] OFS_DIR   = 8'h14;
  localparam logic [7:0] OFS_SIZE  = 8'h18;
  localparam logic [7:0] OFS_ADDR  = 8'h1C;
  localparam logic [7:0] OFS_WDAT  = 8'h20;
  localparam logic [7:0] OFS_ICLR  = 8'h40;
  localparam logic [7:0] OFS_IMSK  = 8'h44;
  localparam logic [7:0] OFS_ISTAT = 8'h48;
  localparam logic [7:0] OFS_RTY   = 8'h64;
  localparam logic [7:0] OFS_STAT  = 8'h80;
  localparam logic [7:0] OFS_RDAT  = 8'h84;

  typedef enum logic [1:0] {ENG_IDLE, ENG_REQ, ENG_GAP} eng_state_t;

  typedef struct packed {
    logic              rd;
    logic [1:0]        size;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } xfer_cmd_t;

  // Packed so that tmo lands on status bit 4 and ack_hw on bit 0.
  typedef struct packed {
    logic tmo;
    logic rty;
    logic err;
    logic ack_fw;
    logic ack_hw;
  } xfer_flags_t;

  function automatic logic [DATA_W-1:0] size_mask_data(input logic [1:0] sz,
                                                       input logic [DATA_W-1:0] d);
    case (sz)
      2'd0:    return {{(DATA_W-8){1'b0}}, d[7:0]};
      2'd1:    return {{(DATA_W-16){1'b0}}, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic xfer_flags_t end_flags(input logic is_err, input logic is_rty,
                                            input logic is_tmo, input logic [1:0] sz);
    xfer_flags_t f;
    f.err    = is_err;
    f.rty    = is_rty;
    f.tmo    = is_tmo;
    f.ack_fw = !is_err && !is_rty && !is_tmo && sz[1];
    f.ack_hw = !is_err && !is_rty && !is_tmo && !sz[1];
    return f;
  endfunction
endpackage

// File: rtl/rtb_engine.sv
module rtb_engine
  import rtb_pkg::*;
#(
  parameter int TMO_CYC = 64,
  parameter int RTY_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  xfer_cmd_t         cmd,
  input  logic [RTY_W-1:0]  rty_max,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic              dn_retry,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              busy,
  output logic              done,
  output xfer_flags_t       flags,
  output logic [DATA_W-1:0] rdata_cap,
  output logic              dn_req,
  output logic              dn_we,
  output logic [1:0]        dn_size,
  output logic [DATA_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata
);
  localparam int TC_W = $clog2(TMO_CYC + 1);

  eng_state_t        state;
  xfer_cmd_t         cur;
  logic [RTY_W-1:0]  rmax;
  logic [RTY_W-1:0]  rcnt;
  logic [TC_W-1:0]   tcnt;
  xfer_flags_t       flags_q;
  logic [DATA_W-1:0] rdata_q;

  // named internal events
  logic in_req, saw_err, saw_rty, saw_ack, tmo_hit, rty_again, rty_final, start;
  assign in_req    = (state == ENG_REQ);
  assign start     = launch && (state == ENG_IDLE);
  assign saw_err   = in_req && dn_err;
  assign saw_rty   = in_req && dn_retry && !dn_err;
  assign saw_ack   = in_req && dn_ack && !dn_err && !dn_retry;
  assign tmo_hit   = in_req && !(dn_ack || dn_err || dn_retry) && (tcnt == TC_W'(TMO_CYC - 1));
  assign rty_again = saw_rty && (rcnt != rmax);
  assign rty_final = saw_rty && (rcnt == rmax);
  assign done      = saw_err || saw_ack || rty_final || tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      cur     <= '0;
      rmax    <= '0;
      rcnt    <= '0;
      tcnt    <= '0;
      flags_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (start) begin
          state   <= ENG_REQ;
          cur     <= cmd;
          rmax    <= rty_max;
          rcnt    <= '0;
          tcnt    <= '0;
          flags_q <= '0;
        end
        ENG_REQ: begin
          if (done) begin
            state   <= ENG_IDLE;
            flags_q <= end_flags(saw_err, rty_final, tmo_hit, cur.size);
            if (saw_ack && cur.rd) rdata_q <= size_mask_data(cur.size, dn_rdata);
          end else if (rty_again) begin
            state <= ENG_GAP;
            rcnt  <= rcnt + 1'b1;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ENG_GAP: state <= ENG_REQ;
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy      = (state != ENG_IDLE);
  assign flags     = flags_q;
  assign rdata_cap = rdata_q;
  assign dn_req    = in_req;
  assign dn_we     = !cur.rd;
  assign dn_size   = cur.size;
  assign dn_addr   = cur.addr;
  assign dn_wdata  = cur.wdata;

  assert_rty_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rcnt <= rmax));
  assert_gap_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rty_again |=> !dn_req ##1 dn_req);
  assert_tmo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_req |-> (int'(tcnt) < TMO_CYC));
  assert_hold_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !done && !rty_again) |=> (dn_req && $stable(dn_addr) && $stable(dn_size) && $stable(dn_wdata)));
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_err_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && dn_err) |=> (flags.err && !flags.ack_fw && !flags.ack_hw && !flags.rty));
endmodule

// File: rtl/rtb_regs.sv
module rtb_regs
  import rtb_pkg::*;
#(
  parameter int               OFS_W   = 8,
  parameter int               RTY_W   = 8,
  parameter logic [RTY_W-1:0] RTY_RST = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  xfer_flags_t       flags,
  input  logic [DATA_W-1:0] rdata_cap,
  output logic              launch,
  output xfer_cmd_t         cmd,
  output logic [RTY_W-1:0]  rty_max,
  output logic              irq
);
  logic              dir_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] addr_q, wdat_q;
  logic [RTY_W-1:0]  rty_q;
  logic              mask_q, istat_q;

  logic wr, clr_hit;
  logic [7:0] ofs8;
  assign ofs8    = 8'(reg_ofs);
  assign wr      = reg_sel && reg_we;
  assign launch  = wr && (ofs8 == OFS_TRIG) && reg_wdata[0];
  assign clr_hit = wr && (ofs8 == OFS_ICLR) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rty_q   <= RTY_RST;
      mask_q  <= 1'b0;
      istat_q <= 1'b0;
    end else begin
      if (wr) begin
        case (ofs8)
          OFS_DIR:  dir_q  <= reg_wdata[0];
          OFS_SIZE: size_q <= reg_wdata[1:0];
          OFS_ADDR: addr_q <= reg_wdata;
          OFS_WDAT: wdat_q <= reg_wdata;
          OFS_RTY:  rty_q  <= reg_wdata[RTY_W-1:0];
          OFS_IMSK: mask_q <= reg_wdata[ISTAT_BIT];
          default: ;
        endcase
      end
      if (done)         istat_q <= 1'b1;
      else if (clr_hit) istat_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (ofs8)
      OFS_DIR:   reg_rdata[0] = dir_q;
      OFS_SIZE:  reg_rdata[1:0] = size_q;
      OFS_ADDR:  reg_rdata = addr_q;
      OFS_WDAT:  reg_rdata = wdat_q;
      OFS_RTY:   reg_rdata[RTY_W-1:0] = rty_q;
      OFS_IMSK:  reg_rdata[ISTAT_BIT] = mask_q;
      OFS_ISTAT: reg_rdata[ISTAT_BIT] = istat_q;
      OFS_STAT:  reg_rdata[BUSY_BIT:0] = {busy, flags};
      OFS_RDAT:  reg_rdata = rdata_cap;
      default:   reg_rdata = '0;
    endcase
  end

  assign cmd.rd    = dir_q;
  assign cmd.size  = size_q;
  assign cmd.addr  = addr_q;
  assign cmd.wdata = wdat_q;
  assign rty_max   = rty_q;
  assign irq       = istat_q && mask_q;

  assert_set_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> istat_q);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_q && !clr_hit) |=> istat_q);
  assert_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(istat_q) |-> $past(done));
  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> mask_q);
endmodule

// File: rtl/regtrig_bridge.sv
module regtrig_bridge
  import rtb_pkg::*;
#(
  parameter int OFS_W   = 8,
  parameter int RTY_W   = 8,
  parameter int TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              dn_req,
  output logic              dn_we,
  output logic [1:0]        dn_size,
  output logic [31:0]       dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic              dn_retry,
  input  logic [31:0]       dn_rdata
);
  logic              launch, busy, done;
  xfer_cmd_t         cmd;
  xfer_flags_t       flags;
  logic [RTY_W-1:0]  rty_max;
  logic [DATA_W-1:0] rdata_cap;

  rtb_regs #(.OFS_W(OFS_W), .RTY_W(RTY_W), .RTY_RST(RTY_W'(16))) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .flags(flags), .rdata_cap(rdata_cap),
    .launch(launch), .cmd(cmd), .rty_max(rty_max), .irq(irq)
  );

  rtb_engine #(.TMO_CYC(TMO_CYC), .RTY_W(RTY_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .cmd(cmd), .rty_max(rty_max),
    .dn_ack(dn_ack), .dn_err(dn_err), .dn_retry(dn_retry), .dn_rdata(dn_rdata),
    .busy(busy), .done(done), .flags(flags), .rdata_cap(rdata_cap),
    .dn_req(dn_req), .dn_we(dn_we), .dn_size(dn_size),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata)
  );

  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> (dn_req && dn_we == !$past(cmd.rd) && dn_addr == $past(cmd.addr)));
  assert_ignore_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && busy && !done) |=> (busy && $stable(dn_addr) && $stable(dn_we)));
endmodule

// File: tb/sim_regtrig_bridge.sv
module sim_regtrig_bridge;
  localparam int TMO = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, reg_sel, reg_we, irq, dn_req, dn_we, dn_ack, dn_err, dn_retry;
  logic [7:0]  reg_ofs;
  logic [31:0] reg_wdata, reg_rdata, dn_addr, dn_wdata, dn_rdata;
  logic [1:0]  dn_size;

  regtrig_bridge #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .dn_req(dn_req), .dn_we(dn_we), .dn_size(dn_size), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_err(dn_err), .dn_retry(dn_retry),
    .dn_rdata(dn_rdata)
  );

  int checks = 0, errors = 0;
  bit all_done = 0;

  // responder state
  int lat = 1, rty_left = 0, wcnt = 0, attempts = 0, req_cyc = 0, field_bad = 0;
  logic [2:0]  fin = 3'b001;   // {err, retry, ack}
  logic        prev_req = 1'b0, exp_we;
  logic [1:0]  exp_size;
  logic [31:0] exp_addr, exp_wdata;

  always @(negedge clk) begin
    dn_ack = 1'b0; dn_err = 1'b0; dn_retry = 1'b0;
    if (dn_req === 1'b1) begin
      req_cyc++;
      if (!prev_req) attempts++;
      if (dn_addr !== exp_addr || dn_we !== exp_we || dn_size !== exp_size || dn_wdata !== exp_wdata)
        field_bad++;
      if (wcnt >= lat) begin
        wcnt = 0;
        if (rty_left > 0) begin dn_retry = 1'b1; rty_left--; end
        else {dn_err, dn_retry, dn_ack} = fin;
      end else wcnt++;
    end else wcnt = 0;
    prev_req = (dn_req === 1'b1);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_ofs = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_ofs = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  function automatic logic [31:0] ack_status(input logic [1:0] sz);
    return sz[1] ? 32'h2 : 32'h1;
  endfunction

  function automatic logic [31:0] trim_data(input logic [1:0] sz, input logic [31:0] v);
    if (sz == 2'd0) return v & 32'hFF;
    if (sz == 2'd1) return v & 32'hFFFF;
    return v;
  endfunction

  task automatic stage(input bit rd, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, input logic [31:0] rdv,
                       input int l, input int nr, input logic [2:0] f);
    host_write(8'h14, {31'b0, rd});
    host_write(8'h18, {30'b0, sz});
    host_write(8'h1C, a);
    host_write(8'h20, wd);
    exp_we = !rd; exp_size = sz; exp_addr = a; exp_wdata = wd;
    dn_rdata = rdv; lat = l; rty_left = nr; fin = f;
    attempts = 0; req_cyc = 0; field_bad = 0;
    host_write(8'h40, 32'h1);
  endtask

  task automatic wait_done(output logic [31:0] st, output logic [31:0] rdo);
    logic [31:0] v;
    for (int i = 0; i < 600; i++) begin
      host_read(8'h48, v);
      if (v[16]) break;
    end
    host_read(8'h80, st);
    host_read(8'h84, rdo);
  endtask

  task automatic xfer(input bit rd, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, input logic [31:0] rdv,
                      input int l, input int nr, input logic [2:0] f,
                      output logic [31:0] st, output logic [31:0] rdo);
    stage(rd, sz, a, wd, rdv, l, nr, f);
    host_write(8'h04, 32'h1);
    wait_done(st, rdo);
  endtask

  initial begin
    logic [31:0] v, st, rdo, last_rd;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; reg_sel = 1'b0; reg_we = 1'b0; reg_ofs = '0; reg_wdata = '0;
    dn_rdata = '0; exp_we = 1'b1; exp_size = '0; exp_addr = '0; exp_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    host_read(8'h80, v); chk("R1 status", v, 32'h0);
    host_read(8'h48, v); chk("R1 istat", v, 32'h0);
    host_read(8'h44, v); chk("R1 mask", v, 32'h0);
    host_read(8'h84, v); chk("R1 rdata", v, 32'h0);
    host_read(8'h64, v); chk("R1 retry limit", v, 32'h10);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 req", {31'b0, dn_req}, 32'h0);

    // R2 readback
    host_write(8'h14, 32'hFFFF_FFFF); host_read(8'h14, v); chk("R2 dir", v, 32'h1);
    host_write(8'h18, 32'hFFFF_FFFE); host_read(8'h18, v); chk("R2 size", v, 32'h2);
    host_write(8'h1C, 32'hA5C3_1234); host_read(8'h1C, v); chk("R2 addr", v, 32'hA5C3_1234);
    host_write(8'h20, 32'h0BAD_F00D); host_read(8'h20, v); chk("R2 wdata", v, 32'h0BAD_F00D);
    host_write(8'h64, 32'h1234_5677); host_read(8'h64, v); chk("R2 retry", v, 32'h77);
    host_write(8'h44, 32'hFFFF_FFFF); host_read(8'h44, v); chk("R2 mask", v, 32'h0001_0000);
    host_write(8'h44, 32'h0);
    host_read(8'h04, v); chk("R2 trigger reads zero", v, 32'h0);
    host_read(8'h30, v); chk("R2 unmapped", v, 32'h0);
    host_write(8'h64, 32'h2);

    // R5/R6/R7 random traffic, R3 request fields each time
    last_rd = 32'h0;
    for (int n = 0; n < 40; n++) begin
      bit rd; logic [1:0] sz; logic [31:0] a, wd, rv; int l; logic [2:0] f;
      rd = 1'($urandom); sz = (n % 3 == 0) ? 2'd0 : ((n % 3 == 1) ? 2'd1 : 2'd3);
      a = $urandom; wd = $urandom; rv = $urandom; l = 1 + int'($urandom % 4);
      f = ($urandom % 5 == 0) ? 3'b100 : 3'b001;
      xfer(rd, sz, a, wd, rv, l, 0, f, st, rdo);
      if (f == 3'b100) chk("R7 error status", st, 32'h4);
      else             chk("R5 ack status", st, ack_status(sz));
      if (rd && f == 3'b001) last_rd = trim_data(sz, rv);
      chk("R6 read data", rdo, last_rd);
      chk("R3 request fields", field_bad, 0);
      chk("R3 single attempt", attempts, 1);
    end

    // R3 + R4 launch, busy, ignored trigger, mid-flight register write
    stage(1'b0, 2'd3, 32'h1111_2222, 32'h3333_4444, 32'h0, 14, 0, 3'b001);
    host_write(8'h04, 32'h1);
    host_read(8'h80, v); chk("R3 busy with flags cleared", v, 32'h20);
    host_write(8'h1C, 32'hDEAD_0000);
    host_write(8'h04, 32'h1);
    wait_done(st, rdo);
    chk("R4 fields unchanged", field_bad, 0);
    chk("R4 one attempt", attempts, 1);
    chk("R5 fullword write ack", st, 32'h2);
    chk("R6 write keeps rdata", rdo, last_rd);
    repeat (6) @(negedge clk);
    chk("R4 no queued launch", {31'b0, dn_req}, 32'h0);
    host_write(8'h04, 32'h0);
    repeat (3) @(negedge clk);
    chk("R3 trigger bit0 clear", {31'b0, dn_req}, 32'h0);

    // R8 retries, limit 2
    xfer(1'b1, 2'd1, 32'h40, 32'h0, 32'hCAFE_BEEF, 1, 1, 3'b001, st, rdo);
    chk("R8 retry then ack status", st, 32'h1);
    chk("R8 retry then ack attempts", attempts, 2);
    chk("R8 reissue fields", field_bad, 0);
    chk("R6 halfword read", rdo, 32'hBEEF);
    last_rd = 32'hBEEF;
    xfer(1'b1, 2'd3, 32'h44, 32'h0, 32'h1, 2, 5, 3'b001, st, rdo);
    chk("R8 exhausted status", st, 32'h8);
    chk("R8 exhausted attempts", attempts, 3);
    chk("R6 retry keeps rdata", rdo, last_rd);
    host_write(8'h64, 32'h0);
    xfer(1'b0, 2'd0, 32'h48, 32'h5, 32'h0, 1, 1, 3'b001, st, rdo);
    chk("R8 zero limit status", st, 32'h8);
    chk("R8 zero limit attempts", attempts, 1);

    // R10 priority
    xfer(1'b1, 2'd3, 32'h50, 32'h0, 32'h77, 1, 0, 3'b111, st, rdo);
    chk("R10 error beats all", st, 32'h4);
    chk("R10 error no capture", rdo, last_rd);
    xfer(1'b1, 2'd3, 32'h54, 32'h0, 32'h77, 1, 0, 3'b011, st, rdo);
    chk("R10 retry beats ack", st, 32'h8);
    host_write(8'h64, 32'h1);
    xfer(1'b1, 2'd0, 32'h58, 32'h0, 32'h1234_56AB, 1, 0, 3'b011, st, rdo);
    chk("R10 retry beats ack twice", attempts, 2);

    // R9 timeout
    xfer(1'b0, 2'd3, 32'h60, 32'h9, 32'h0, 1, 0, 3'b000, st, rdo);
    chk("R9 timeout status", st, 32'h10);
    chk("R9 request cycles", req_cyc, TMO);
    xfer(1'b0, 2'd3, 32'h64, 32'h9, 32'h0, 3, 1, 3'b000, st, rdo);
    chk("R9 timeout after retry", st, 32'h10);
    chk("R9 counter restarts", req_cyc, 4 + TMO);

    // R11 / R12 completion bit and interrupt
    host_read(8'h48, v); chk("R11 sticky with mask off", v, 32'h0001_0000);
    chk("R12 irq masked", {31'b0, irq}, 32'h0);
    host_write(8'h40, 32'h0);
    host_read(8'h48, v); chk("R11 clear needs bit0", v, 32'h0001_0000);
    host_write(8'h44, 32'h0001_0000);
    #1 chk("R12 irq raised", {31'b0, irq}, 32'h1);
    host_write(8'h40, 32'h1);
    host_read(8'h48, v); chk("R11 cleared", v, 32'h0);
    chk("R12 irq dropped", {31'b0, irq}, 32'h0);
    stage(1'b0, 2'd3, 32'h70, 32'h1, 32'h0, 1, 0, 3'b001);
    host_write(8'h04, 32'h1);
    host_write(8'h40, 32'h1);
    host_read(8'h48, v); chk("R11 set wins over clear", v, 32'h0001_0000);
    chk("R12 irq on completion", {31'b0, irq}, 32'h1);

    all_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule